// File: doc/BRIEF.md
# Noise-Limited Bandwidth Autotuner

This block is a supervisor for a disturbance-rejecting feedback controller. It drives the two tuning parameters of that controller: the estimator bandwidth and the loop bandwidth. It starts both at small seed values. Then, one window at a time, it raises them until the jitter in the actuator command reaches a tolerance that software sets. For each window it keeps two running totals of the command samples: their sum and the sum of their squares. From these totals it forms the population spread of the window. If the spread is under the tolerance, both bandwidths move up by their own increments and a new window starts. If the spread is at or over the tolerance, the bandwidths are frozen and a locked flag is raised.

Another part of the system decides when the loop has settled. It reports this through the enable input. Dropping enable at any time discards the window in progress and leaves the bandwidths at their current values. Raising enable again continues tuning from those values. The tolerance, the window length, the increments and the upper limits are all live inputs. Each bandwidth is clamped at its own limit, and reaching a limit also ends tuning.

Top module: `bw_autotune`

## Requirements
- R1: While rst_n is low, obs_bw takes obs_bw_init, ctl_bw takes ctl_bw_init and locked is low. These values are visible after the first clock edge with reset low.
- R2: While enable is low, no sample is counted and locked is low. Both bandwidths keep their values. A window cut short by enable going low is discarded. A later window counts only samples strobed after enable has returned high.
- R3: win_len is captured at the start of each window. A captured value below 2 is used as 2. A sample is counted only on an edge where sample_valid is high and a window is open. Strobes in the two cycles that follow a window's last sample are ignored.
- R4: With n samples x, the block forms D = n·Σx² − (Σx)² and L = (n·noise_thr)². D < L raises the bandwidths. D ≥ L locks. This is the same as comparing the population standard deviation with noise_thr, using unsigned samples.
- R5: A raise sets each bandwidth to min(value + its step, its max). A fresh window then opens and the new win_len is captured.
- R6: If a raise brings either bandwidth to its max, the block locks instead of opening a new window.
- R7: While locked and enabled, both bandwidths and locked stay unchanged, whatever samples arrive. After enable is dropped and raised again, tuning continues from the held bandwidths.
- R8: Let edge k be the edge that takes a window's last sample. A lock decision shows on locked after edge k+1. A raise shows on the bandwidths after edge k+2, and the next window counts samples from edge k+3 on.
- R9: The accumulators do not overflow. A window of 255 full-scale samples gives D = 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| enable | input | 1 | Loop has settled; tuning may proceed |
| sample_valid | input | 1 | Strobe for sample_data |
| sample_data | input | SAMPLE_W | Unsigned actuator command sample |
| win_len | input | CNT_W | Samples per window (values below 2 are used as 2) |
| noise_thr | input | THR_W | Spread tolerance, in sample units |
| obs_bw_init | input | BW_W | Estimator bandwidth loaded at reset |
| ctl_bw_init | input | BW_W | Loop bandwidth loaded at reset |
| obs_bw_step | input | BW_W | Estimator bandwidth increment |
| ctl_bw_step | input | BW_W | Loop bandwidth increment |
| obs_bw_max | input | BW_W | Estimator bandwidth limit |
| ctl_bw_max | input | BW_W | Loop bandwidth limit |
| obs_bw | output | BW_W | Current estimator bandwidth |
| ctl_bw | output | BW_W | Current loop bandwidth |
| locked | output | 1 | Tuning finished; bandwidths frozen |

## Verification
Edge k is the edge that takes a window's last sample. The lock decision is due after edge k+1, and a raise of the bandwidths is due after edge k+2. The bench drives every input at the falling edge. It reads locked at the falling edge after k+1, and reads locked and both bandwidths again at the falling edge after k+2. The timing tests place strobes exactly on edges k+1 and k+2. A changed latency would move those strobes into a counted window, and the decision would then change. Checks that enable-low holds the state are made two falling edges after the drop, before enable returns.

// File: rtl/at_pkg.sv
// Package: shared state type for the bandwidth autotuner.
// Assumes: the encoding is not visible outside the block.
package at_pkg;
    typedef enum logic [2:0] {
        ST_IDLE,
        ST_ACCUM,
        ST_EVAL,
        ST_STEP,
        ST_LOCKED
    } tune_state_t;
endpackage

// File: rtl/at_stat_accum.sv
// Module: running sum, sum of squares and count over one window.
// Assumes: unsigned samples; at most 2**CNT_W-1 adds between clears, so the
// widths below cannot overflow.
module at_stat_accum #(
    parameter int SAMPLE_W = 12,
    parameter int CNT_W    = 8,
    localparam int SUM_W   = SAMPLE_W + CNT_W,
    localparam int SQ_W    = 2 * SAMPLE_W + CNT_W
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                clear,
    input  logic                add,
    input  logic [SAMPLE_W-1:0] sample,
    output logic [SUM_W-1:0]    sum,
    output logic [SQ_W-1:0]     sumsq,
    output logic [CNT_W-1:0]    count
);
    logic [2*SAMPLE_W-1:0] square;

    // square of the incoming sample
    always_comb square = sample * sample;

    // accumulate on add, zero on clear or reset
    always_ff @(posedge clk) begin
        if (!rst_n || clear) begin
            sum   <= '0;
            sumsq <= '0;
            count <= '0;
        end else if (add) begin
            sum   <= sum + SUM_W'(sample);
            sumsq <= sumsq + SQ_W'(square);
            count <= count + CNT_W'(1);
        end
    end
endmodule

// File: rtl/at_var_compare.sv
// Module: decides whether the spread of a window is below tolerance, without
// a square root: n*S2 - S1^2 < (n*thr)^2.
// Assumes: sum/sumsq come from n unsigned samples, so the spread is >= 0.
module at_var_compare #(
    parameter int SAMPLE_W = 12,
    parameter int CNT_W    = 8,
    parameter int THR_W    = 12,
    localparam int SUM_W   = SAMPLE_W + CNT_W,
    localparam int SQ_W    = 2 * SAMPLE_W + CNT_W,
    localparam int D_W     = 2 * SUM_W,
    localparam int L_W     = 2 * (CNT_W + THR_W),
    localparam int CMP_W   = (D_W > L_W) ? D_W : L_W
) (
    input  logic [CNT_W-1:0] n,
    input  logic [SUM_W-1:0] sum,
    input  logic [SQ_W-1:0]  sumsq,
    input  logic [THR_W-1:0] thr,
    output logic             below
);
    logic [CMP_W-1:0] n_x, s1_x, s2_x, nt_x;
    logic [CMP_W-1:0] spread, limit;

    // widen operands to the compare width
    always_comb begin
        n_x  = CMP_W'(n);
        s1_x = CMP_W'(sum);
        s2_x = CMP_W'(sumsq);
        nt_x = CMP_W'(n) * CMP_W'(thr);
    end

    // scaled variance against scaled squared tolerance
    always_comb begin
        spread = (n_x * s2_x) - (s1_x * s1_x);
        limit  = nt_x * nt_x;
        below  = spread < limit;
    end
endmodule

// File: rtl/at_bw_stepper.sv
// Module: one bandwidth register, seeded at reset, raised by a step and
// clamped at a limit.
// Assumes: the seed input is stable while reset is low.
module at_bw_stepper #(
    parameter int BW_W = 16
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic [BW_W-1:0] seed,
    input  logic [BW_W-1:0] step,
    input  logic [BW_W-1:0] limit,
    input  logic            do_step,
    output logic [BW_W-1:0] bw,
    output logic            hit_limit
);
    logic [BW_W:0]   raised;
    logic [BW_W-1:0] next_bw;

    // candidate value and whether it meets the limit
    always_comb begin
        raised    = {1'b0, bw} + {1'b0, step};
        hit_limit = raised >= {1'b0, limit};
        next_bw   = hit_limit ? limit : raised[BW_W-1:0];
    end

    // seed on reset, apply a step when told
    always_ff @(posedge clk) begin
        if (!rst_n)
            bw <= seed;
        else if (do_step)
            bw <= next_bw;
    end
endmodule

// File: rtl/bw_autotune.sv
// Module: noise-limited bandwidth autotuner. Collects a window of actuator
// samples, compares their spread with a tolerance, raises both bandwidths
// while below it, and locks once it is reached or a limit is hit.
// Assumes: enable signals that the loop has settled; all tuning inputs are
// quasi-static while a window is in progress.
module bw_autotune #(
    parameter int SAMPLE_W = 12,
    parameter int CNT_W    = 8,
    parameter int THR_W    = 12,
    parameter int BW_W     = 16
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                enable,
    input  logic                sample_valid,
    input  logic [SAMPLE_W-1:0] sample_data,
    input  logic [CNT_W-1:0]    win_len,
    input  logic [THR_W-1:0]    noise_thr,
    input  logic [BW_W-1:0]     obs_bw_init,
    input  logic [BW_W-1:0]     ctl_bw_init,
    input  logic [BW_W-1:0]     obs_bw_step,
    input  logic [BW_W-1:0]     ctl_bw_step,
    input  logic [BW_W-1:0]     obs_bw_max,
    input  logic [BW_W-1:0]     ctl_bw_max,
    output logic [BW_W-1:0]     obs_bw,
    output logic [BW_W-1:0]     ctl_bw,
    output logic                locked
);
    import at_pkg::*;

    localparam int SUM_W  = SAMPLE_W + CNT_W;
    localparam int SQ_W   = 2 * SAMPLE_W + CNT_W;
    localparam int NUM_BW = 2;

    tune_state_t      state, state_nx;
    logic [CNT_W-1:0] n_lat, win_eff;
    logic [SUM_W-1:0] acc_sum;
    logic [SQ_W-1:0]  acc_sq;
    logic [CNT_W-1:0] acc_cnt;
    logic             acc_clear, acc_add, last_sample, spread_below;
    logic             do_step, any_hit, open_window;

    logic [BW_W-1:0]  seed_a  [NUM_BW];
    logic [BW_W-1:0]  step_a  [NUM_BW];
    logic [BW_W-1:0]  limit_a [NUM_BW];
    logic [BW_W-1:0]  bw_a    [NUM_BW];
    logic             hit_a   [NUM_BW];

    // effective window length, never below two samples
    always_comb win_eff = (win_len < CNT_W'(2)) ? CNT_W'(2) : win_len;

    // accumulator control and end-of-window detection
    always_comb begin
        acc_add     = enable && (state == ST_ACCUM) && sample_valid;
        acc_clear   = !enable || (state == ST_IDLE) || (state == ST_STEP)
                      || (state == ST_LOCKED);
        last_sample = acc_add && (acc_cnt == n_lat - CNT_W'(1));
        do_step     = enable && (state == ST_STEP);
    end

    at_stat_accum #(.SAMPLE_W(SAMPLE_W), .CNT_W(CNT_W)) u_accum (
        .clk    (clk),
        .rst_n  (rst_n),
        .clear  (acc_clear),
        .add    (acc_add),
        .sample (sample_data),
        .sum    (acc_sum),
        .sumsq  (acc_sq),
        .count  (acc_cnt)
    );

    at_var_compare #(.SAMPLE_W(SAMPLE_W), .CNT_W(CNT_W), .THR_W(THR_W)) u_cmp (
        .n     (n_lat),
        .sum   (acc_sum),
        .sumsq (acc_sq),
        .thr   (noise_thr),
        .below (spread_below)
    );

    // map the two bandwidth channels onto arrays
    always_comb begin
        seed_a[0]  = obs_bw_init;
        seed_a[1]  = ctl_bw_init;
        step_a[0]  = obs_bw_step;
        step_a[1]  = ctl_bw_step;
        limit_a[0] = obs_bw_max;
        limit_a[1] = ctl_bw_max;
    end

    for (genvar gi = 0; gi < NUM_BW; gi++) begin : g_bw
        at_bw_stepper #(.BW_W(BW_W)) u_step (
            .clk       (clk),
            .rst_n     (rst_n),
            .seed      (seed_a[gi]),
            .step      (step_a[gi]),
            .limit     (limit_a[gi]),
            .do_step   (do_step),
            .bw        (bw_a[gi]),
            .hit_limit (hit_a[gi])
        );
    end

    // any channel reaching its limit on this step
    always_comb begin
        any_hit = 1'b0;
        for (int i = 0; i < NUM_BW; i++)
            any_hit = any_hit | hit_a[i];
    end

    // next-state logic of the tuning sequence
    always_comb begin
        state_nx = state;
        if (!enable) begin
            state_nx = ST_IDLE;
        end else begin
            unique case (state)
                ST_IDLE:   state_nx = ST_ACCUM;
                ST_ACCUM:  if (last_sample) state_nx = ST_EVAL;
                ST_EVAL:   state_nx = spread_below ? ST_STEP : ST_LOCKED;
                ST_STEP:   state_nx = any_hit ? ST_LOCKED : ST_ACCUM;
                ST_LOCKED: state_nx = ST_LOCKED;
                default:   state_nx = ST_IDLE;
            endcase
        end
        open_window = (state_nx == ST_ACCUM) && (state != ST_ACCUM);
    end

    // state register and window length capture
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state <= ST_IDLE;
            n_lat <= CNT_W'(2);
        end else begin
            state <= state_nx;
            if (open_window)
                n_lat <= win_eff;
        end
    end

    // outputs
    always_comb begin
        obs_bw = bw_a[0];
        ctl_bw = bw_a[1];
        locked = (state == ST_LOCKED);
    end
endmodule

// File: rtl/bw_autotune_chk.sv
// Module: property checker for the bandwidth autotuner, bound to the top.
// Assumes: observes top-level ports only.
module bw_autotune_chk #(
    parameter int BW_W = 16
) (
    input logic            clk,
    input logic            rst_n,
    input logic            enable,
    input logic            locked,
    input logic [BW_W-1:0] obs_bw,
    input logic [BW_W-1:0] ctl_bw,
    input logic [BW_W-1:0] obs_bw_max,
    input logic [BW_W-1:0] ctl_bw_max
);
    // R5: a bandwidth at or under a steady limit stays under it
    assert_bw_within_max_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (obs_bw <= obs_bw_max && ctl_bw <= ctl_bw_max
         && $stable(obs_bw_max) && $stable(ctl_bw_max))
        |=> (obs_bw <= obs_bw_max && ctl_bw <= ctl_bw_max));

    // R5: bandwidths only move upward while under their limits
    assert_bw_monotone_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (obs_bw <= obs_bw_max && ctl_bw <= ctl_bw_max)
        |=> (obs_bw >= $past(obs_bw) && ctl_bw >= $past(ctl_bw)));

    // R7: locked and enabled freezes everything
    assert_locked_freeze_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (locked && enable) |=> (locked && $stable(obs_bw) && $stable(ctl_bw)));

    // R2: dropping enable clears the lock on the next cycle
    assert_disable_unlocks_R2: assert property (@(posedge clk) disable iff (!rst_n)
        !enable |=> !locked);

    // R2: a lock only appears out of an enabled cycle
    assert_lock_needs_enable_R2: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(locked) |-> $past(enable));
endmodule

bind bw_autotune bw_autotune_chk #(.BW_W(BW_W)) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .enable     (enable),
    .locked     (locked),
    .obs_bw     (obs_bw),
    .ctl_bw     (ctl_bw),
    .obs_bw_max (obs_bw_max),
    .ctl_bw_max (ctl_bw_max)
);

// File: tb/bw_autotune_test.sv
module bw_autotune_test;
    localparam int SAMPLE_W = 12;
    localparam int CNT_W    = 8;
    localparam int THR_W    = 12;
    localparam int BW_W     = 16;
    localparam int NVEC     = 7;
    // win_len, noise_thr, lo sample, hi sample (samples alternate lo, hi, ...)
    localparam int VEC [NVEC][4] = '{
        '{20, 10, 100, 110},
        '{20,  5, 100, 110},
        '{20,  6, 100, 110},
        '{10,  1, 500, 500},
        '{ 1,  3,   0,   6},
        '{ 7, 50,   0, 100},
        '{ 7, 49,   0, 100}
    };

    logic clk = 1'b0;
    logic rst_n, enable, sample_valid;
    logic [SAMPLE_W-1:0] sample_data;
    logic [CNT_W-1:0]    win_len;
    logic [THR_W-1:0]    noise_thr;
    logic [BW_W-1:0] obs_bw_init, ctl_bw_init, obs_bw_step, ctl_bw_step;
    logic [BW_W-1:0] obs_bw_max, ctl_bw_max, obs_bw, ctl_bw;
    logic locked;

    int checks = 0;
    int failures = 0;
    longint exp_obs, exp_ctl;

    always #2 clk = ~clk;

    bw_autotune #(.SAMPLE_W(SAMPLE_W), .CNT_W(CNT_W), .THR_W(THR_W), .BW_W(BW_W)) uut (
        .clk(clk), .rst_n(rst_n), .enable(enable), .sample_valid(sample_valid),
        .sample_data(sample_data), .win_len(win_len), .noise_thr(noise_thr),
        .obs_bw_init(obs_bw_init), .ctl_bw_init(ctl_bw_init),
        .obs_bw_step(obs_bw_step), .ctl_bw_step(ctl_bw_step),
        .obs_bw_max(obs_bw_max), .ctl_bw_max(ctl_bw_max),
        .obs_bw(obs_bw), .ctl_bw(ctl_bw), .locked(locked)
    );

    task automatic chk(input string req, input longint act, input longint exp);
        checks++;
        if (act != exp) begin
            failures++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic tick();
        @(negedge clk);
    endtask

    // close any window, set config, reopen
    task automatic restart(input int wl, input int thr);
        enable = 1'b0;
        tick();
        win_len = CNT_W'(wl);
        noise_thr = THR_W'(thr);
        enable = 1'b1;
        tick();
    endtask

    task automatic feed(input int n, input int lo, input int hi);
        for (int i = 0; i < n; i++) begin
            sample_valid = 1'b1;
            sample_data = SAMPLE_W'((i % 2 == 0) ? lo : hi);
            tick();
        end
        sample_valid = 1'b0;
    endtask

    // expected step decision from the spread rule
    function automatic bit want_step(input int n, input int thr, input int lo, input int hi);
        longint s1 = 0, s2 = 0;
        for (int i = 0; i < n; i++) begin
            longint x = (i % 2 == 0) ? lo : hi;
            s1 += x;
            s2 += x * x;
        end
        return (longint'(n) * s2 - s1 * s1) < (longint'(n) * n * thr * thr);
    endfunction

    // feed a window, check locked after k+1 and results after k+2
    task automatic window(input int wl, input int thr, input int lo, input int hi,
                          input string req);
        int n = (wl < 2) ? 2 : wl;
        bit st = want_step(n, thr, lo, hi);
        bit hit = 1'b0;
        restart(wl, thr);
        feed(n, lo, hi);
        tick();
        chk({req, " R8 lock after k+1"}, locked, st ? 0 : 1);
        tick();
        if (st) begin
            hit = (exp_obs + obs_bw_step >= obs_bw_max) || (exp_ctl + ctl_bw_step >= ctl_bw_max);
            exp_obs = (exp_obs + obs_bw_step >= obs_bw_max) ? obs_bw_max : exp_obs + obs_bw_step;
            exp_ctl = (exp_ctl + ctl_bw_step >= ctl_bw_max) ? ctl_bw_max : exp_ctl + ctl_bw_step;
        end
        chk({req, " R5 obs_bw"}, obs_bw, exp_obs);
        chk({req, " R5 ctl_bw"}, ctl_bw, exp_ctl);
        chk({req, " R6 locked after k+2"}, locked, (!st || hit) ? 1 : 0);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        failures++;
        $display("FAIL watchdog expired");
        $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        rst_n = 1'b0; enable = 1'b0; sample_valid = 1'b0; sample_data = '0;
        win_len = 8'd20; noise_thr = 12'd10;
        obs_bw_init = 16'd10; ctl_bw_init = 16'd20;
        obs_bw_step = 16'd5;  ctl_bw_step = 16'd3;
        obs_bw_max = 16'd1000; ctl_bw_max = 16'd1000;
        repeat (3) tick();
        // R1: reset state
        chk("R1 obs_bw seed", obs_bw, 10);
        chk("R1 ctl_bw seed", ctl_bw, 20);
        chk("R1 locked low", locked, 0);
        rst_n = 1'b1;
        tick();
        exp_obs = 10; exp_ctl = 20;

        // R4 / R3 table: decision rule, boundary equality, clamp of win_len
        for (int v = 0; v < NVEC; v++)
            window(VEC[v][0], VEC[v][1], VEC[v][2], VEC[v][3], v == 4 ? "R3 R4" : "R4");

        // R2: drop enable mid-window; partial window discarded, bw kept
        restart(8, 2);
        feed(5, 0, 4000);
        enable = 1'b0;
        tick(); tick();
        chk("R2 locked while disabled", locked, 0);
        chk("R2 obs_bw held", obs_bw, exp_obs);
        chk("R2 ctl_bw held", ctl_bw, exp_ctl);
        enable = 1'b1;
        tick();
        feed(8, 300, 300);
        tick(); tick();
        exp_obs += 5; exp_ctl += 3;
        chk("R2 fresh window obs_bw", obs_bw, exp_obs);
        chk("R2 fresh window locked", locked, 0);

        // R3: strobes at edges k+1 and k+2 are ignored
        restart(4, 2);
        feed(4, 700, 700);
        sample_valid = 1'b1; sample_data = 12'd0;    tick();
        sample_data = 12'd4095;                      tick();
        feed(4, 700, 700);
        tick(); tick();
        exp_obs += 10; exp_ctl += 6;
        chk("R3 obs_bw after two windows", obs_bw, exp_obs);
        chk("R3 ctl_bw after two windows", ctl_bw, exp_ctl);
        chk("R3 not locked", locked, 0);

        // R9: full-scale window of maximum length
        window(255, 1, 4095, 4095, "R9");

        // R6: obs limit reached by a clamped step forces lock
        obs_bw_max = BW_W'(exp_obs + 2);
        window(4, 2, 900, 900, "R6");
        chk("R6 obs_bw clamped", obs_bw, obs_bw_max);

        // R7: locked ignores samples, re-enable resumes from held values
        feed(6, 0, 4000);
        tick(); tick(); tick();
        chk("R7 locked held", locked, 1);
        chk("R7 obs_bw frozen", obs_bw, exp_obs);
        chk("R7 ctl_bw frozen", ctl_bw, exp_ctl);
        enable = 1'b0;
        tick();
        chk("R2 unlock on disable", locked, 0);
        window(4, 2, 900, 900, "R7");

        $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule